// File: doc/BRIEF.md
# Repeating Block-Copy Bus Sequencer

This block runs a memory-to-memory byte copy the way an 8-bit processor runs its repeat-copy instruction. It owns a source pointer, a destination pointer, a 16-bit byte count and the address of the copy instruction. On every iteration it fetches both instruction bytes from memory again and runs a refresh cycle between the two fetches. It then reads one byte from the source, writes that byte to the destination, steps both pointers, decrements the count and decides whether to go round again. All traffic goes over one single-port memory bus. The bus carries an address, read, write and refresh strobes, and a flag that marks instruction fetches.

Fetching the instruction again on each iteration keeps the copy correct in two cases: the copy overwrites its own instruction bytes, or memory behind the instruction address changes. If a fetched byte is not the expected copy instruction, the sequencer stops and reports that byte. An interrupt request is only taken at the end of an iteration. The pointers and count are then left consistent, so the copy can be restarted from the same instruction address and will finish the job.

Top module: `blkcopy_seq`

## Requirements
- R1: Each full iteration makes its bus accesses in this fixed order: fetch of the first instruction byte at the instruction address with the fetch flag high, one refresh cycle, fetch of the second byte at instruction address + 1 with the fetch flag high, a read at the source pointer, and a write to the destination pointer.
- R2: In base timing an iteration that repeats lasts 21 cycles: first fetch 2, refresh 2, second fetch 2, decode 2, read 3, write 3, update 2, repeat branch 5. The last iteration skips the repeat branch and lasts 16 cycles.
- R3: When the slow-fetch input is high at start, the first instruction fetch of every iteration lasts 3 cycles instead of 2. A repeating iteration then lasts 22 cycles and the last one 17.
- R4: After every copied byte the count drops by one modulo 2^16. The sequencer repeats while the new count is non-zero. Completion raises `done` for exactly one cycle, on the cycle after the last update cycle. A count of 0 at start means 65536 transfers.
- R5: The first byte is checked against OP_FIRST (default 0xED) at the end of the refresh phase. The second byte is checked against OP_SECOND (default 0xB0) at the end of the decode phase. On a mismatch the sequencer goes idle without copying, pulses `alien` for one cycle and holds the offending byte on `alien_op`. Pointers and count stay as they were at the start of that iteration.
- R6: `irq` is sampled only on the last cycle of the repeat branch. If it is high, the sequencer goes idle and pulses `halted` for one cycle. `src_q`, `dst_q` and `cnt_q` then describe the remaining work, so a new start with those values and the same instruction address completes the copy.
- R7: With `dir_dec` low at start, both pointers increment after each byte; with it high, both decrement. Both pointers wrap modulo 2^16.
- R8: The refresh cycle drives address {0x00, r}. Bits 6..0 of the 8-bit register r advance by one, modulo 128, at the end of each instruction-byte fetch. Bit 7 of r keeps its reset value 0.
- R9: At most one of `mem_rd`, `mem_wr` and `mem_rfsh` is high in any cycle. `mem_m1` is high only together with `mem_rd`. No strobe is high while idle.
- R10: A start pulse while busy is ignored and has no effect on the bus trace or the result.
- R11: After reset the sequencer is idle, all strobes and status pulses are low, and the pointers, count and r are zero.
- R12: The byte written in an iteration equals the byte read from the source in that same iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the operands and begin; ignored while busy |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Byte count (0 means 65536) |
| pc_i | input | 16 | Address of the first instruction byte |
| dir_dec | input | 1 | 1: pointers decrement, 0: increment |
| slow_fetch | input | 1 | Adds one wait cycle to the first fetch |
| irq | input | 1 | Interrupt request, taken between iterations |
| mem_rdata | input | 8 | Read data, sampled on the last cycle of a read or fetch |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rfsh | output | 1 | Refresh strobe |
| mem_m1 | output | 1 | Marks an instruction-byte fetch |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle pulse: copy completed |
| halted | output | 1 | One-cycle pulse: stopped by interrupt |
| alien | output | 1 | One-cycle pulse: fetched byte was not the copy instruction |
| alien_op | output | 8 | Last offending instruction byte |
| src_q | output | 16 | Current source pointer |
| dst_q | output | 16 | Current destination pointer |
| cnt_q | output | 16 | Current remaining count |

## Verification
A wrong phase or cycle counter shows up within one cycle on the bus. The strobe, the fetch flag or the address no longer matches the expected per-cycle trace, and that trace is compared on every clock. A wrong pointer or a wrong refresh register shows on the very next read, write or refresh address. A wrong count or a misjudged repeat decision shifts the end of the run: `done`, `halted` or `alien` fires one or more iterations away from the expected cycle, and the final register outputs and memory contents differ.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int TICK_W = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_FETCH1,
        PH_RFSH,
        PH_FETCH2,
        PH_DECODE,
        PH_READ,
        PH_WRITE,
        PH_UPDATE,
        PH_REPEAT
    } phase_e;

    typedef enum logic [1:0] {
        FIN_NONE,
        FIN_DONE,
        FIN_IRQ,
        FIN_ALIEN
    } fin_e;

    typedef struct packed {
        addr_t addr;
        byte_t wdata;
        logic  rd;
        logic  wr;
        logic  rfsh;
        logic  m1;
    } bus_t;

    localparam int unsigned LEN_FETCH  = 2;
    localparam int unsigned LEN_RFSH   = 2;
    localparam int unsigned LEN_DECODE = 2;
    localparam int unsigned LEN_READ   = 3;
    localparam int unsigned LEN_WRITE  = 3;
    localparam int unsigned LEN_UPDATE = 2;
    localparam int unsigned LEN_REPEAT = 5;

    // Index of the final cycle of a phase.
    function automatic tick_t phase_last(input phase_e ph, input logic slow);
        int unsigned n;
        case (ph)
            PH_FETCH1: n = LEN_FETCH + (slow ? 1 : 0);
            PH_RFSH:   n = LEN_RFSH;
            PH_FETCH2: n = LEN_FETCH;
            PH_DECODE: n = LEN_DECODE;
            PH_READ:   n = LEN_READ;
            PH_WRITE:  n = LEN_WRITE;
            PH_UPDATE: n = LEN_UPDATE;
            PH_REPEAT: n = LEN_REPEAT;
            default:   n = 1;
        endcase
        return tick_t'(n - 1);
    endfunction

    // Low seven bits advance, top bit kept.
    function automatic byte_t rfsh_step(input byte_t r);
        return {r[DATA_W-1], r[DATA_W-2:0] + {{(DATA_W-2){1'b0}}, 1'b1}};
    endfunction

    function automatic addr_t ptr_step(input addr_t p, input logic dec);
        return dec ? p - addr_t'(1) : p + addr_t'(1);
    endfunction

endpackage

// File: rtl/blkcopy_phase.sv
module blkcopy_phase
    import blkcopy_pkg::*;
#(
    parameter byte_t OP_FIRST  = 8'hED,
    parameter byte_t OP_SECOND = 8'hB0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   slow,
    input  logic   irq,
    input  byte_t  op1,
    input  byte_t  op2,
    input  logic   cnt_last,
    output phase_e ph,
    output logic   last,
    output fin_e   fin,
    output byte_t  alien_code
);

    tick_t cyc;
    logic  slow_q;

    always_comb last = (cyc == phase_last(ph, slow_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            cyc        <= '0;
            fin        <= FIN_NONE;
            alien_code <= '0;
            slow_q     <= 1'b0;
        end else begin
            fin <= FIN_NONE;
            if (ph == PH_IDLE) begin
                cyc <= '0;
                if (start) begin
                    ph     <= PH_FETCH1;
                    slow_q <= slow;
                end
            end else if (!last) begin
                cyc <= cyc + tick_t'(1);
            end else begin
                cyc <= '0;
                case (ph)
                    PH_FETCH1: ph <= PH_RFSH;
                    PH_RFSH: begin
                        if (op1 != OP_FIRST) begin
                            ph         <= PH_IDLE;
                            fin        <= FIN_ALIEN;
                            alien_code <= op1;
                        end else begin
                            ph <= PH_FETCH2;
                        end
                    end
                    PH_FETCH2: ph <= PH_DECODE;
                    PH_DECODE: begin
                        if (op2 != OP_SECOND) begin
                            ph         <= PH_IDLE;
                            fin        <= FIN_ALIEN;
                            alien_code <= op2;
                        end else begin
                            ph <= PH_READ;
                        end
                    end
                    PH_READ:  ph <= PH_WRITE;
                    PH_WRITE: ph <= PH_UPDATE;
                    PH_UPDATE: begin
                        if (cnt_last) begin
                            ph  <= PH_IDLE;
                            fin <= FIN_DONE;
                        end else begin
                            ph <= PH_REPEAT;
                        end
                    end
                    PH_REPEAT: begin
                        if (irq) begin
                            ph  <= PH_IDLE;
                            fin <= FIN_IRQ;
                        end else begin
                            ph <= PH_FETCH1;
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/blkcopy_regs.sv
module blkcopy_regs
    import blkcopy_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  addr_t  src_i,
    input  addr_t  dst_i,
    input  cnt_t   cnt_i,
    input  addr_t  pc_i,
    input  logic   dir_dec,
    input  phase_e ph,
    input  logic   last,
    input  byte_t  rdata,
    output addr_t  src,
    output addr_t  dst,
    output cnt_t   cnt,
    output addr_t  pc,
    output byte_t  rref,
    output byte_t  op1,
    output byte_t  op2,
    output byte_t  data
);

    logic dec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src   <= '0;
            dst   <= '0;
            cnt   <= '0;
            pc    <= '0;
            rref  <= '0;
            op1   <= '0;
            op2   <= '0;
            data  <= '0;
            dec_q <= 1'b0;
        end else if (load) begin
            src   <= src_i;
            dst   <= dst_i;
            cnt   <= cnt_i;
            pc    <= pc_i;
            dec_q <= dir_dec;
        end else if (last) begin
            case (ph)
                PH_FETCH1: begin
                    op1  <= rdata;
                    rref <= rfsh_step(rref);
                end
                PH_FETCH2: begin
                    op2  <= rdata;
                    rref <= rfsh_step(rref);
                end
                PH_READ: data <= rdata;
                PH_UPDATE: begin
                    src <= ptr_step(src, dec_q);
                    dst <= ptr_step(dst, dec_q);
                    cnt <= cnt - cnt_t'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/blkcopy_bus.sv
module blkcopy_bus
    import blkcopy_pkg::*;
#(
    parameter logic [ADDR_W-DATA_W-1:0] RFSH_PAGE = '0
) (
    input  phase_e ph,
    input  addr_t  pc,
    input  addr_t  src,
    input  addr_t  dst,
    input  byte_t  rref,
    input  byte_t  data,
    output bus_t   bus
);

    always_comb begin
        bus       = '0;
        bus.wdata = data;
        case (ph)
            PH_FETCH1: begin
                bus.addr = pc;
                bus.rd   = 1'b1;
                bus.m1   = 1'b1;
            end
            PH_RFSH: begin
                bus.addr = {RFSH_PAGE, rref};
                bus.rfsh = 1'b1;
            end
            PH_FETCH2: begin
                bus.addr = pc + addr_t'(1);
                bus.rd   = 1'b1;
                bus.m1   = 1'b1;
            end
            PH_READ: begin
                bus.addr = src;
                bus.rd   = 1'b1;
            end
            PH_WRITE: begin
                bus.addr = dst;
                bus.wr   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
    import blkcopy_pkg::*;
#(
    parameter byte_t OP_FIRST  = 8'hED,
    parameter byte_t OP_SECOND = 8'hB0,
    parameter logic [ADDR_W-DATA_W-1:0] RFSH_PAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              dir_dec,
    input  logic              slow_fetch,
    input  logic              irq,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_rfsh,
    output logic              mem_m1,
    output logic              busy,
    output logic              done,
    output logic              halted,
    output logic              alien,
    output logic [DATA_W-1:0] alien_op,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q
);

    phase_e ph;
    logic   last;
    fin_e   fin;
    addr_t  pc;
    byte_t  rref, op1, op2, data;
    bus_t   bus;
    logic   load;

    assign load = start && (ph == PH_IDLE);

    blkcopy_phase #(
        .OP_FIRST (OP_FIRST),
        .OP_SECOND(OP_SECOND)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .slow      (slow_fetch),
        .irq       (irq),
        .op1       (op1),
        .op2       (op2),
        .cnt_last  (cnt_q == cnt_t'(1)),
        .ph        (ph),
        .last      (last),
        .fin       (fin),
        .alien_code(alien_op)
    );

    blkcopy_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .src_i  (src_i),
        .dst_i  (dst_i),
        .cnt_i  (cnt_i),
        .pc_i   (pc_i),
        .dir_dec(dir_dec),
        .ph     (ph),
        .last   (last),
        .rdata  (mem_rdata),
        .src    (src_q),
        .dst    (dst_q),
        .cnt    (cnt_q),
        .pc     (pc),
        .rref   (rref),
        .op1    (op1),
        .op2    (op2),
        .data   (data)
    );

    blkcopy_bus #(
        .RFSH_PAGE(RFSH_PAGE)
    ) u_bus (
        .ph  (ph),
        .pc  (pc),
        .src (src_q),
        .dst (dst_q),
        .rref(rref),
        .data(data),
        .bus (bus)
    );

    assign mem_addr  = bus.addr;
    assign mem_wdata = bus.wdata;
    assign mem_rd    = bus.rd;
    assign mem_wr    = bus.wr;
    assign mem_rfsh  = bus.rfsh;
    assign mem_m1    = bus.m1;
    assign busy      = (ph != PH_IDLE);
    assign done      = (fin == FIN_DONE);
    assign halted    = (fin == FIN_IRQ);
    assign alien     = (fin == FIN_ALIEN);

endmodule

// File: rtl/blkcopy_seq_chk.sv
module blkcopy_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        irq,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        mem_rfsh,
    input logic        mem_m1,
    input logic        busy,
    input logic        done,
    input logic        halted,
    input logic        alien,
    input logic [15:0] cnt_q
);

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_rd, mem_wr, mem_rfsh}) <= 1);

    p_m1_read_r9: assert property (@(posedge clk) disable iff (rst)
        mem_m1 |-> (mem_rd && !mem_wr));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_rd || mem_wr || mem_rfsh));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(start) && !$stable(cnt_q)) |-> (cnt_q == $past(cnt_q) - 16'd1));

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
        halted |-> ($past(irq) && !busy));

    p_alien_idle_r5: assert property (@(posedge clk) disable iff (rst)
        alien |-> (!busy && !done && !halted));

    p_rfsh_top_bit_r8: assert property (@(posedge clk) disable iff (rst)
        mem_rfsh |-> (mem_addr[7] == 1'b0 && mem_addr[15:8] == 8'h00));

endmodule

bind blkcopy_seq blkcopy_seq_chk u_chk (.*);

// File: tb/blkcopy_seq_bench.sv
`timescale 1ns/1ps
module blkcopy_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0, pc_i = '0;
    logic        dir_dec = 1'b0, slow_fetch = 1'b0, irq = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, mem_rfsh, mem_m1;
    logic        busy, done, halted, alien;
    logic [7:0]  alien_op;
    logic [15:0] src_q, dst_q, cnt_q;

    always #2.5 clk = ~clk;

    blkcopy_seq u_blkcopy_seq (
        .clk(clk), .rst(rst), .start(start), .src_i(src_i), .dst_i(dst_i),
        .cnt_i(cnt_i), .pc_i(pc_i), .dir_dec(dir_dec), .slow_fetch(slow_fetch),
        .irq(irq), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rfsh(mem_rfsh), .mem_m1(mem_m1),
        .busy(busy), .done(done), .halted(halted), .alien(alien), .alien_op(alien_op),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q)
    );

    bit [7:0] mem [int];
    bit [7:0] ref_mem [int];
    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    typedef struct {
        bit        rd, wr, rf, m1;
        bit [15:0] addr;
        bit [7:0]  wd;
    } exp_t;
    exp_t q[$];

    bit [7:0]  mr = 8'h00;
    bit [15:0] ms, md, mc;
    int        kind;
    bit [7:0]  kcode;

    // Bus-side memory, driven away from the active edge.
    always @(negedge clk) begin
        if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
        mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic bit [7:0] rget(input bit [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic put(input bit [15:0] a, input bit [7:0] v);
        mem[int'(a)] = v;
        ref_mem[int'(a)] = v;
    endtask

    task automatic push(input int n, input bit rd, input bit wr, input bit rf,
                        input bit m1, input bit [15:0] a, input bit [7:0] wd);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.rd = rd; e.wr = wr; e.rf = rf; e.m1 = m1; e.addr = a; e.wd = wd;
            q.push_back(e);
        end
    endtask

    function automatic bit [7:0] rnext(input bit [7:0] r);
        return {r[7], 7'(r[6:0] + 7'd1)};
    endfunction

    // Behavioural model: expected bus trace and end state.
    task automatic model(input bit [15:0] s, input bit [15:0] d, input bit [15:0] c,
                         input bit [15:0] p, input bit dec, input bit slow, input bit irqv);
        bit [7:0] op1, op2, v;
        q.delete();
        ms = s; md = d; mc = c;
        forever begin
            op1 = rget(p);
            push(slow ? 3 : 2, 1, 0, 0, 1, p, 0);
            mr = rnext(mr);
            push(2, 0, 0, 1, 0, {8'h00, mr}, 0);
            if (op1 != 8'hED) begin kind = 3; kcode = op1; break; end
            op2 = rget(p + 16'd1);
            push(2, 1, 0, 0, 1, p + 16'd1, 0);
            mr = rnext(mr);
            push(2, 0, 0, 0, 0, 0, 0);
            if (op2 != 8'hB0) begin kind = 3; kcode = op2; break; end
            v = rget(ms);
            push(3, 1, 0, 0, 0, ms, 0);
            push(3, 0, 1, 0, 0, md, v);
            ref_mem[int'(md)] = v;
            push(2, 0, 0, 0, 0, 0, 0);
            ms = dec ? ms - 16'd1 : ms + 16'd1;
            md = dec ? md - 16'd1 : md + 16'd1;
            mc = mc - 16'd1;
            if (mc == 16'd0) begin kind = 1; break; end
            push(5, 0, 0, 0, 0, 0, 0);
            if (irqv) begin kind = 2; break; end
        end
    endtask

    task automatic run(input bit [15:0] s, input bit [15:0] d, input bit [15:0] c,
                       input bit [15:0] p, input bit dec, input bit slow, input bit irqv,
                       input bit poke, input string tag);
        int n = 0;
        int bad_cyc = 0;
        model(s, d, c, p, dec, slow, irqv);
        @(negedge clk);
        src_i = s; dst_i = d; cnt_i = c; pc_i = p;
        dir_dec = dec; slow_fetch = slow; irq = irqv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            // R1 R9: strobe, fetch flag and address every cycle
            if (!(busy === 1'b1 && mem_rd === e.rd && mem_wr === e.wr && mem_rfsh === e.rf &&
                  mem_m1 === e.m1 && (!(e.rd || e.wr || e.rf) || mem_addr === e.addr) &&
                  (!e.wr || mem_wdata === e.wd))) begin
                if (bad_cyc < 4)
                    $display("FAIL %s R1 cycle %0d: actual rd%0b wr%0b rf%0b m1%0b a%h d%h expected rd%0b wr%0b rf%0b m1%0b a%h d%h",
                             tag, n, mem_rd, mem_wr, mem_rfsh, mem_m1, mem_addr, mem_wdata,
                             e.rd, e.wr, e.rf, e.m1, e.addr, e.wd);
                bad_cyc++;
            end
            if (poke && n == 10) begin
                start = 1'b1; src_i = 16'hDEAD; dst_i = 16'hBEEF; cnt_i = 16'h0003; pc_i = 16'h7777;
            end else begin
                start = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        chk(bad_cyc == 0, tag, "bus trace mismatching cycles", bad_cyc, 0);
        chk(busy == 1'b0, tag, "busy after expected end", busy, 0);
        chk(done == (kind == 1), tag, "done pulse (R4)", done, kind == 1);
        chk(halted == (kind == 2), tag, "halted pulse (R6)", halted, kind == 2);
        chk(alien == (kind == 3), tag, "alien pulse (R5)", alien, kind == 3);
        if (kind == 3) chk(alien_op == kcode, tag, "alien_op (R5)", alien_op, kcode);
        chk(src_q == ms, tag, "src_q", src_q, ms);
        chk(dst_q == md, tag, "dst_q", dst_q, md);
        chk(cnt_q == mc, tag, "cnt_q", cnt_q, mc);
        @(negedge clk);
        chk(!(done || halted || alien), tag, "status pulse width", {done, halted, alien}, 0);
        begin
            int bad_mem = 0;
            foreach (ref_mem[k]) begin
                if (!mem.exists(k) || mem[k] != ref_mem[k]) bad_mem++;
            end
            chk(bad_mem == 0, tag, "memory bytes differing (R12)", bad_mem, 0);
        end
        irq = 1'b0;
    endtask

    task automatic setup(input bit [15:0] p, input bit [15:0] s, input int len, input bit dec);
        mem.delete();
        ref_mem.delete();
        put(p, 8'hED);
        put(p + 16'd1, 8'hB0);
        for (int i = 0; i < len; i++) begin
            bit [15:0] a;
            a = dec ? s - 16'(i) : s + 16'(i);
            put(a, 8'(i * 37 + 5));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(busy == 0 && mem_rd == 0 && mem_wr == 0 && mem_rfsh == 0 && mem_m1 == 0,
            "R11", "idle strobes", {busy, mem_rd, mem_wr, mem_rfsh, mem_m1}, 0);
        chk(!(done || halted || alien), "R11", "status after reset", {done, halted, alien}, 0);
        chk(src_q == 0 && dst_q == 0 && cnt_q == 0, "R11", "registers after reset",
            {src_q, dst_q, cnt_q}, 0);

        // R2 R12: forward copy, base timing
        setup(16'h1000, 16'h2000, 5, 0);
        run(16'h2000, 16'h3000, 16'd5, 16'h1000, 0, 0, 0, 0, "R2");

        // R7: decrementing copy
        setup(16'h1000, 16'h2104, 4, 1);
        run(16'h2104, 16'h3104, 16'd4, 16'h1000, 1, 0, 0, 0, "R7");

        // R3: slow first fetch
        setup(16'h1000, 16'h2000, 3, 0);
        run(16'h2000, 16'h3000, 16'd3, 16'h1000, 0, 1, 0, 0, "R3");

        // R7: pointer wrap past 0xFFFF
        setup(16'h1000, 16'hFFFE, 3, 0);
        run(16'hFFFE, 16'hFFFF, 16'd3, 16'h1000, 0, 0, 0, 0, "R7");

        // R10: start while busy ignored
        setup(16'h1000, 16'h2000, 3, 0);
        run(16'h2000, 16'h3000, 16'd3, 16'h1000, 0, 0, 0, 1, "R10");

        // R6: interrupt after one iteration, then resume to completion
        setup(16'h1000, 16'h0400, 6, 0);
        run(16'h0400, 16'h0500, 16'd6, 16'h1000, 0, 0, 1, 0, "R6");
        run(ms, md, mc, 16'h1000, 0, 0, 0, 0, "R6");

        // R4: count of zero wraps to 0xFFFF after one byte
        setup(16'h1000, 16'h0600, 2, 0);
        run(16'h0600, 16'h0700, 16'd0, 16'h1000, 0, 0, 1, 0, "R4");

        // R5: copy overwrites its own first byte
        setup(16'h0100, 16'h0200, 5, 0);
        run(16'h0200, 16'h00FF, 16'd5, 16'h0100, 0, 0, 0, 0, "R5");

        // R5: wrong second byte, no copy
        setup(16'h0300, 16'h0200, 2, 0);
        put(16'h0301, 8'h11);
        run(16'h0200, 16'h0800, 16'd2, 16'h0300, 0, 0, 0, 0, "R5");

        // R8: refresh register wraps over a long copy
        setup(16'h1000, 16'h4000, 70, 0);
        run(16'h4000, 16'h5000, 16'd70, 16'h1000, 0, 0, 0, 0, "R8");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule